// File: doc/BRIEF.md
# Timestamp Phase Detector with Multi-Period Range

This block sits between edge detection and a digital loop filter. A fast system clock drives a free-running tick counter. Each single-cycle strobe marking a rising edge of the reference clock, or of the feedback clock, is stamped with that counter's value. Strobes arrive already synchronized to the system clock. The block pairs the edges of the two streams in arrival order and forms a signed error word: the reference time minus the feedback time, in ticks. The word goes to the loop filter with a one-cycle valid pulse.

The error is not folded into one input period. It keeps growing while one stream runs ahead of the other. Only the latest stamp of each side is stored, together with a per-side edge count. When one side leads by k edges, the missing stamp is projected back by k nominal periods. Subtraction is modular on the stamp counter, so counter rollover cancels out. Results outside the output range clamp to the extreme codes and raise a sticky overflow flag.

Top module: `tsphase_det`

## Requirements
- R1: A TS_W-bit tick counter runs from zero after reset and stamps each strobe with its value at the sampling edge. Subtraction is modulo 2^TS_W, so rollover of the counter does not change the error when the true separation is below 2^(TS_W-1) ticks.
- R2: The n-th reference edge is paired with the n-th feedback edge, and err_word = t_ref - t_fb in ticks. The value is negative when feedback lags and positive when feedback leads.
- R3: When the reference count exceeds the feedback count by k, err_word = last_ref_stamp - last_fb_stamp - k*PERIOD_TICKS. Offsets of many periods are therefore reported in full and not wrapped.
- R4: err_valid is high for exactly the one cycle after each sampling edge where either strobe is high, provided each side has had at least one edge since reset. Simultaneous strobes give a single event. There is no pulse otherwise.
- R5: err_word holds its last value in cycles without an event.
- R6: edge_lead = (reference edges - feedback edges) modulo 2^CNT_W, read as signed. It updates in the cycle after each strobe.
- R7: An error above 2^(ERR_W-1)-1 outputs that maximum code, and one below -2^(ERR_W-1) outputs that minimum code. Either case sets err_ovf, which stays set until reset.
- R8: With default parameters (TS_W 32, CNT_W 16, ERR_W 16, PERIOD_TICKS 8) a lead of 1125 periods is represented without overflow. For example, 1126 reference edges every 2 ticks followed by one feedback edge 2 ticks later give -9002.
- R9: A synchronous active-high reset clears the tick counter, stamps, counts, err_word, err_valid and err_ovf to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_stb | input | 1 | Reference rising-edge strobe, one cycle wide |
| fb_stb | input | 1 | Feedback rising-edge strobe, one cycle wide |
| err_valid | output | 1 | One-cycle pulse for each comparison event |
| err_word | output | ERR_W | Signed phase error in ticks (reference minus feedback) |
| err_ovf | output | 1 | Sticky flag: an error was clamped |
| edge_lead | output | CNT_W | Signed count of reference edges minus feedback edges |

## Verification
Each output is registered one stage behind the sampling edge. After a strobe is sampled at edge k, err_valid, err_word, err_ovf and edge_lead all show the result in the cycle that follows edge k. The bench changes strobes on the falling edge. It then waits through one rising edge and reads every output at the next falling edge, which is exactly the cycle the result is due. Cycles without strobes are read the same way, to confirm that no pulse appears and that the error holds.

// File: rtl/tsphase_det.sv
`timescale 1ns/1ps
module tsphase_det #(
  parameter int TS_W         = 32,
  parameter int CNT_W        = 16,
  parameter int ERR_W        = 16,
  parameter int PERIOD_TICKS = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ref_stb,
  input  logic                    fb_stb,
  output logic                    err_valid,
  output logic signed [ERR_W-1:0] err_word,
  output logic                    err_ovf,
  output logic signed [CNT_W-1:0] edge_lead
);
  localparam int PW   = $clog2(PERIOD_TICKS + 1) + 1;
  localparam int WIDE = TS_W + CNT_W + PW + 1;
  localparam logic signed [WIDE-1:0] MAXV = {{(WIDE-ERR_W+1){1'b0}}, {(ERR_W-1){1'b1}}};
  localparam logic signed [WIDE-1:0] MINV = {{(WIDE-ERR_W+1){1'b1}}, {(ERR_W-1){1'b0}}};
  localparam logic signed [ERR_W-1:0] MAXC = {1'b0, {(ERR_W-1){1'b1}}};
  localparam logic signed [ERR_W-1:0] MINC = {1'b1, {(ERR_W-1){1'b0}}};
  localparam logic signed [WIDE-1:0] PER = WIDE'(PERIOD_TICKS);

  logic [TS_W-1:0]  tick, ref_ts, fb_ts;
  logic [CNT_W-1:0] ref_cnt, fb_cnt;
  logic             ref_seen, fb_seen;

  wire [TS_W-1:0]  ref_ts_n   = ref_stb ? tick : ref_ts;
  wire [TS_W-1:0]  fb_ts_n    = fb_stb ? tick : fb_ts;
  wire [CNT_W-1:0] ref_cnt_n  = ref_cnt + CNT_W'(ref_stb);
  wire [CNT_W-1:0] fb_cnt_n   = fb_cnt + CNT_W'(fb_stb);
  wire             both_seen  = (ref_seen | ref_stb) & (fb_seen | fb_stb);
  wire             evt        = (ref_stb | fb_stb) & both_seen;
  wire [TS_W-1:0]  ts_diff    = ref_ts_n - fb_ts_n;
  wire [CNT_W-1:0] lead_n     = ref_cnt_n - fb_cnt_n;

  logic signed [WIDE-1:0] ts_wide, lead_wide, raw;
  logic signed [ERR_W-1:0] err_next;
  logic over;

  always_comb begin
    ts_wide   = WIDE'($signed(ts_diff));
    lead_wide = WIDE'($signed(lead_n));
    raw       = ts_wide - lead_wide * PER;
    over      = (raw > MAXV) || (raw < MINV);
    if (raw > MAXV)      err_next = MAXC;
    else if (raw < MINV) err_next = MINC;
    else                 err_next = raw[ERR_W-1:0];
  end

  assign edge_lead = ref_cnt - fb_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick      <= '0;
      ref_ts    <= '0;
      fb_ts     <= '0;
      ref_cnt   <= '0;
      fb_cnt    <= '0;
      ref_seen  <= 1'b0;
      fb_seen   <= 1'b0;
      err_valid <= 1'b0;
      err_word  <= '0;
      err_ovf   <= 1'b0;
    end else begin
      tick      <= tick + 1'b1;
      ref_ts    <= ref_ts_n;
      fb_ts     <= fb_ts_n;
      ref_cnt   <= ref_cnt_n;
      fb_cnt    <= fb_cnt_n;
      ref_seen  <= ref_seen | ref_stb;
      fb_seen   <= fb_seen | fb_stb;
      err_valid <= evt;
      if (evt) err_word <= err_next;
      err_ovf   <= err_ovf | (evt & over);
    end
  end

  AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> $past(ref_stb || fb_stb)); // R4

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!err_valid && !$past(rst)) |-> $stable(err_word)); // R5

  AST_LEAD_STEP: assert property (@(posedge clk) disable iff (rst)
    (ref_stb && !fb_stb) |=> (edge_lead == $past(edge_lead) + CNT_W'(1))); // R6

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_ovf |=> err_ovf); // R7

  AST_CLAMP_CODE: assert property (@(posedge clk) disable iff (rst)
    (err_valid && !$past(rst) && $rose(err_ovf)) |-> (err_word == MAXC || err_word == MINC)); // R7
endmodule

// File: tb/sim_tsphase_det.sv
`timescale 1ns/1ps
module sim_tsphase_det;
  localparam int TS_W = 12, CNT_W = 8, ERR_W = 10, PER = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_stb = 1'b0, fb_stb = 1'b0;
  logic ref1 = 1'b0, fb1 = 1'b0;
  logic err_valid, err_ovf, v1, o1;
  logic signed [ERR_W-1:0] err_word;
  logic signed [CNT_W-1:0] edge_lead;
  logic signed [15:0] e1, l1;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tsphase_det #(.TS_W(TS_W), .CNT_W(CNT_W), .ERR_W(ERR_W), .PERIOD_TICKS(PER)) u0 (
    .clk(clk), .rst(rst), .ref_stb(ref_stb), .fb_stb(fb_stb),
    .err_valid(err_valid), .err_word(err_word), .err_ovf(err_ovf), .edge_lead(edge_lead));

  tsphase_det u1 (
    .clk(clk), .rst(rst), .ref_stb(ref1), .fb_stb(fb1),
    .err_valid(v1), .err_word(e1), .err_ovf(o1), .edge_lead(l1));

  // {feedback delay in ticks, periods, expected error}
  localparam int VEC [7][3] = '{
    '{0, 20, 0}, '{3, 20, -3}, '{-5, 20, 5}, '{20, 20, -20},
    '{-30, 20, 30}, '{100, 20, -100}, '{5, 600, -5}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input bit r, input bit f);
    ref_stb = r; fb_stb = f;
    @(posedge clk);
    @(negedge clk);
    ref_stb = 1'b0; fb_stb = 1'b0;
  endtask

  task automatic run_pattern(input int d, input int k, input int exp);
    int base, last, nr, nf;
    bit r, f, ev;
    do_reset();
    base = 200; nr = 0; nf = 0;
    last = base + PER * (k - 1) + ((d > 0) ? d : 0);
    for (int c = 0; c <= last + 3; c++) begin
      r = (c >= base) && ((c - base) % PER == 0) && ((c - base) / PER < k);
      f = (c >= base + d) && ((c - base - d) % PER == 0) && ((c - base - d) / PER < k);
      step(r, f);
      nr += int'(r); nf += int'(f);
      ev = (r || f) && nr > 0 && nf > 0;
      chk(err_valid == ev, "R4 valid pulse", int'(err_valid), int'(ev));
      if (nr > 0 && nf > 0)
        chk(int'(err_word) == exp, "R2 R3 R1 R5 error word", int'(err_word), exp);
      chk(int'(edge_lead) == nr - nf, "R6 edge lead", int'(edge_lead), nr - nf);
    end
  endtask

  initial begin
    do_reset();
    chk(err_word == 0, "R9 reset error", int'(err_word), 0);
    chk(err_valid == 0, "R9 reset valid", int'(err_valid), 0);
    chk(err_ovf == 0, "R9 reset overflow", int'(err_ovf), 0);
    chk(edge_lead == 0, "R9 reset lead", int'(edge_lead), 0);

    for (int i = 0; i < 7; i++) run_pattern(VEC[i][0], VEC[i][1], VEC[i][2]);

    // R7 negative clamp: 70 reference edges every 2 ticks, then feedback (raw -554)
    do_reset();
    repeat (10) step(0, 0);
    for (int i = 0; i < 70; i++) begin
      step(1, 0);
      if (i == 69) chk(int'(edge_lead) == 70, "R6 lead count", int'(edge_lead), 70);
      chk(err_valid == 0, "R4 no event before both sides", int'(err_valid), 0);
      step(0, 0);
    end
    step(0, 1);
    chk(err_valid == 1, "R7 clamp event", int'(err_valid), 1);
    chk(int'(err_word) == -512, "R7 minimum code", int'(err_word), -512);
    chk(err_ovf == 1, "R7 overflow set", int'(err_ovf), 1);
    repeat (5) step(0, 0);
    chk(err_ovf == 1, "R7 overflow sticky", int'(err_ovf), 1);
    chk(int'(err_word) == -512, "R5 hold after clamp", int'(err_word), -512);
    do_reset();
    chk(err_ovf == 0, "R9 reset clears overflow", int'(err_ovf), 0);

    // R7 positive clamp: feedback leads by 70 edges (raw +554)
    repeat (10) step(0, 0);
    for (int i = 0; i < 70; i++) begin
      step(0, 1);
      step(0, 0);
    end
    step(1, 0);
    chk(int'(err_word) == 511, "R7 maximum code", int'(err_word), 511);
    chk(err_ovf == 1, "R7 overflow set high side", int'(err_ovf), 1);
    chk(int'(edge_lead) == -69, "R6 negative lead", int'(edge_lead), -69);

    // R8 default range: lead of 1125 periods on u1
    do_reset();
    repeat (10) @(negedge clk);
    for (int i = 0; i < 1126; i++) begin
      ref1 = 1'b1; @(posedge clk); @(negedge clk); ref1 = 1'b0;
      @(posedge clk); @(negedge clk);
    end
    fb1 = 1'b1; @(posedge clk); @(negedge clk); fb1 = 1'b0;
    chk(v1 == 1, "R8 event", int'(v1), 1);
    chk(int'(e1) == -9002, "R8 wide error", int'(e1), -9002);
    chk(o1 == 0, "R8 no overflow", int'(o1), 0);
    chk(int'(l1) == 1125, "R8 lead", int'(l1), 1125);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule